// File: doc/BRIEF.md
# Strobe-Forwarded Serial Data Transmitter

This block sends one 16-bit result word to a host over one, two or four serial data lines. A strobe clock travels on its own output next to the data. The host uses that strobe to latch the bits, so it needs no clock of its own and no clock recovery. Every data change is launched together with a strobe edge. In single-rate mode only rising edges launch data, and the host samples on falling edges. In double-rate mode both edges launch data and the host samples on both.

The block runs from a system clock at twice the internal strobe frequency, and the strobe is a registered output. The strobe has two possible sources. It can be generated inside the block, toggling on every system clock. It can also follow an external serial clock, which is brought through a synchronizer: each level change of that clock is reproduced on the strobe. The mode, the lane count and the strobe source are read from input fields only at the moment a transfer starts. Lanes not selected by the lane count are left undriven. Raising the active-low chip select cancels a transfer at once.

Top module: `sss_strobe_serializer`

## Requirements
- R1: After reset the strobe is low, all four lane enables and data bits are 0, and busy and done are low.
- R2: A start pulse is accepted only when all four of these hold: chip select is low, the block is not busy, the mode field is 010b (single rate) or 011b (double rate), and the width field is 00b (1 lane), 01b (2 lanes) or 10b (4 lanes). Any other start leaves busy, strobe and lanes unchanged.
- R3: With the internal source (source input 0), the strobe is still low on the clock after the start is accepted and rises on the next clock. It then toggles on every system clock until the transfer ends.
- R4: The word goes out MSB first, and its MSB leaves with the first strobe rising edge. At each launch, lane k carries the bit k places below the highest bit not yet sent. The next group of bits follows at the next launch.
- R5: In single-rate mode data changes only with strobe rising edges. A transfer has 16/W rising edges (W = lane count) and ends on the falling edge that follows the last of them. This gives 15.5, 7.5 or 3.5 strobe periods.
- R6: In double-rate mode every strobe edge launches a new group. A transfer has 16/W edges and ends on a falling edge. This gives 7.5, 3.5 or 1.5 strobe periods.
- R7: Lanes above the selected count keep their enable and data at 0. The selected lanes are enabled from the first launch until one clock after the final edge.
- R8: With the external source (source input 1), each level change of the external clock appears on the strobe at the third system clock edge after the change. A falling change seen before the first rising change of a transfer is ignored.
- R9: While chip select is high, the next clock edge forces the strobe low, all enables and data to 0, and busy and done low. No done pulse is issued for the cancelled word.
- R10: Changes to the mode, width and source fields during a transfer do not affect that transfer.
- R11: Done is high for exactly one clock, starting at the clock edge that makes the final strobe fall. Busy is low in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the internal strobe rate |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, one clock wide |
| cs_n_i | input | 1 | Active-low chip select; high cancels a transfer |
| word_i | input | 16 | Word to send, captured when a start is accepted |
| sclk_i | input | 1 | External strobe source clock |
| proto_i | input | 3 | Mode field: 010b single rate, 011b double rate |
| width_i | input | 2 | Lane count code: 00b 1, 01b 2, 10b 4 |
| src_ext_i | input | 1 | Strobe source: 0 internal, 1 external clock |
| strobe_o | output | 1 | Forwarded strobe, idles low |
| sdo_o | output | 4 | Serial data lanes |
| sdo_oe_o | output | 4 | Drive enable for each data lane |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock pulse after the final strobe edge |

## Verification
If the edge counter or the captured settings go wrong, the strobe shows the wrong number of edges. The done pulse then comes early or late, and the error is visible on the first transfer in that mode. If the lane shift register is misaligned, a wrong bit appears on a lane at the launch where it first goes wrong: the first strobe edge for a bad MSB position, or a later one for a bad shift amount. A reference model compared every clock catches it there. Errors in the synchronizer delay or in the edge qualification shift the strobe by whole system clocks relative to the external clock. This is visible within the first strobe period.

// File: rtl/sss_pkg.sv
package sss_pkg;

  localparam logic [2:0] PROTO_SDR = 3'b010;
  localparam logic [2:0] PROTO_DDR = 3'b011;

  // Settings latched when a transfer is accepted.
  typedef struct packed {
    logic       ddr;
    logic       ext;
    logic [1:0] wcode;
  } xfer_cfg_t;

endpackage

// File: rtl/sss_sclk_sync.sv
module sss_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  output logic lvl_o,
  output logic prev_o
);

  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[STAGES-1:0], sclk_i};
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign prev_o = pipe_q[STAGES];

endmodule

// File: rtl/sss_edge_gen.sv
module sss_edge_gen (
  input  logic clk,
  input  logic rst,
  input  logic abort_i,
  input  logic active_i,
  input  logic src_ext_i,
  input  logic lvl_i,
  input  logic prev_i,
  output logic ev_o,
  output logic ev_rise_o,
  output logic strobe_o
);

  logic strobe_q;

  // One strobe edge event per qualifying cycle; the first external event must be a rise.
  always_comb begin
    ev_o      = 1'b0;
    ev_rise_o = 1'b0;
    if (active_i) begin
      if (!src_ext_i) begin
        ev_o      = 1'b1;
        ev_rise_o = ~strobe_q;
      end else if ((lvl_i != prev_i) && (lvl_i || strobe_q)) begin
        ev_o      = 1'b1;
        ev_rise_o = lvl_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort_i) strobe_q <= 1'b0;
    else if (ev_o)      strobe_q <= ev_rise_o;
  end

  assign strobe_o = strobe_q;

  assert_ext_no_early_fall_R8: assert property (@(posedge clk) disable iff (rst)
    (active_i && src_ext_i && !strobe_q && !abort_i && lvl_i == 1'b0) |=> !strobe_q);

endmodule

// File: rtl/sss_lane_shifter.sv
module sss_lane_shifter #(
  parameter int DATA_W    = 16,
  parameter int MAX_LANES = 4,
  parameter int CODE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 abort_i,
  input  logic                 load_i,
  input  logic [DATA_W-1:0]    word_i,
  input  logic [CODE_W-1:0]    wcode_i,
  input  logic                 launch_i,
  input  logic                 release_i,
  output logic [MAX_LANES-1:0] sdo_o,
  output logic [MAX_LANES-1:0] oe_o
);

  logic [DATA_W-1:0]    sreg_q;
  logic [MAX_LANES-1:0] sdo_q, oe_q, nxt_bits, lane_mask;
  int                   n_lanes;

  always_comb begin
    n_lanes   = 1 << wcode_i;
    lane_mask = '0;
    for (int i = 0; i < MAX_LANES; i++)
      if (i < n_lanes) lane_mask[i] = 1'b1;
  end

  // Lane k takes the bit k places below the top of the remaining word.
  for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
    assign nxt_bits[l] = (l < n_lanes) ? sreg_q[DATA_W-1-l] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      sdo_q  <= '0;
      oe_q   <= '0;
    end else if (abort_i) begin
      sdo_q  <= '0;
      oe_q   <= '0;
    end else begin
      if (load_i) sreg_q <= word_i;
      if (launch_i) begin
        sdo_q  <= nxt_bits;
        oe_q   <= lane_mask;
        sreg_q <= sreg_q << n_lanes;
      end else if (release_i) begin
        sdo_q  <= '0;
        oe_q   <= '0;
      end
    end
  end

  assign sdo_o = sdo_q;
  assign oe_o  = oe_q;

  assert_oe_contiguous_R7: assert property (@(posedge clk) disable iff (rst)
    ((oe_q + 1'b1) & oe_q) == '0);
  assert_undriven_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (sdo_q & ~oe_q) == '0);

endmodule

// File: rtl/sss_strobe_serializer.sv
module sss_strobe_serializer #(
  parameter int DATA_W      = 16,
  parameter int MAX_LANES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 cs_n_i,
  input  logic [DATA_W-1:0]    word_i,
  input  logic                 sclk_i,
  input  logic [2:0]           proto_i,
  input  logic [1:0]           width_i,
  input  logic                 src_ext_i,
  output logic                 strobe_o,
  output logic [MAX_LANES-1:0] sdo_o,
  output logic [MAX_LANES-1:0] sdo_oe_o,
  output logic                 busy_o,
  output logic                 done_o
);
  import sss_pkg::*;

  localparam int CODE_W = 2;
  localparam int CNT_W  = $clog2(2*DATA_W+1);

  xfer_cfg_t        cfg_q;
  logic             active_q, done_q;
  logic [CNT_W-1:0] cnt_q, total_edges;
  logic             sync_lvl, sync_prev, ev, ev_rise;
  logic             proto_ok, width_ok, start_ok, launch, last_edge;

  assign proto_ok  = (proto_i == PROTO_SDR) || (proto_i == PROTO_DDR);
  assign width_ok  = int'(32'd1 << width_i) <= MAX_LANES;
  assign start_ok  = start_i && !cs_n_i && !active_q && proto_ok && width_ok;

  always_comb begin
    if (cfg_q.ddr) total_edges = CNT_W'(DATA_W >> cfg_q.wcode);
    else           total_edges = CNT_W'((2*DATA_W) >> cfg_q.wcode);
  end

  assign launch    = ev && (ev_rise || cfg_q.ddr);
  assign last_edge = ev && (cnt_q == total_edges - 1'b1);

  sss_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .lvl_o(sync_lvl), .prev_o(sync_prev)
  );

  sss_edge_gen u_edge (
    .clk(clk), .rst(rst), .abort_i(cs_n_i), .active_i(active_q),
    .src_ext_i(cfg_q.ext), .lvl_i(sync_lvl), .prev_i(sync_prev),
    .ev_o(ev), .ev_rise_o(ev_rise), .strobe_o(strobe_o)
  );

  sss_lane_shifter #(.DATA_W(DATA_W), .MAX_LANES(MAX_LANES), .CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst(rst), .abort_i(cs_n_i), .load_i(start_ok), .word_i(word_i),
    .wcode_i(cfg_q.wcode), .launch_i(launch), .release_i(done_q),
    .sdo_o(sdo_o), .oe_o(sdo_oe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (cs_n_i) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (active_q) begin
        if (ev) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_edge) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end else if (start_ok) begin
        cfg_q.ddr   <= proto_i[0];
        cfg_q.ext   <= src_ext_i;
        cfg_q.wcode <= width_i;
        active_q    <= 1'b1;
        cnt_q       <= '0;
      end
    end
  end

  assign busy_o = active_q;
  assign done_o = done_q;

  assert_idle_strobe_low_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !strobe_o);
  assert_cancel_clears_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> (!strobe_o && sdo_oe_o == '0 && !busy_o && !done_o));
  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_with_fall_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> ($fell(strobe_o) && !busy_o));
  assert_internal_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !cfg_q.ext && !cs_n_i) |=> (strobe_o != $past(strobe_o)));
  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(cfg_q));

endmodule

// File: tb/sss_strobe_serializer_bench.sv
module sss_strobe_serializer_bench;

  logic        clk = 1'b0, rst = 1'b1;
  logic        start_i = 1'b0, cs_n_i = 1'b0, sclk_i = 1'b0, src_ext_i = 1'b0;
  logic [15:0] word_i = '0;
  logic [2:0]  proto_i = 3'b010;
  logic [1:0]  width_i = 2'b00;
  logic        strobe_o, busy_o, done_o;
  logic [3:0]  sdo_o, sdo_oe_o;

  int checks = 0, errors = 0;
  bit cmp_en = 1'b0;

  always #5 clk = ~clk;

  sss_strobe_serializer u_sss_strobe_serializer (
    .clk(clk), .rst(rst), .start_i(start_i), .cs_n_i(cs_n_i), .word_i(word_i),
    .sclk_i(sclk_i), .proto_i(proto_i), .width_i(width_i), .src_ext_i(src_ext_i),
    .strobe_o(strobe_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // free-running external clock, period 4 system clocks
  initial forever begin
    repeat (2) @(negedge clk);
    sclk_i = ~sclk_i;
  end

  // ---------------- behavioural reference model ----------------
  bit m_active, m_strobe, m_done, m_ddr, m_ext, ms1, ms2, ms3;
  int m_nl, m_cnt, m_total;
  bit [3:0] m_sdo, m_oe;
  bit mq[$];

  always @(posedge clk) begin
    bit ev, rise;
    if (rst) begin
      m_active = 0; m_strobe = 0; m_done = 0; m_ddr = 0; m_ext = 0;
      m_nl = 1; m_cnt = 0; m_total = 32; m_sdo = 0; m_oe = 0;
      ms1 = 0; ms2 = 0; ms3 = 0; mq.delete();
    end else begin
      ev = 0; rise = 0;
      if (m_active) begin
        if (!m_ext) begin ev = 1; rise = !m_strobe; end
        else if (ms2 != ms3 && (ms2 || m_strobe)) begin ev = 1; rise = ms2; end
      end
      ms3 = ms2; ms2 = ms1; ms1 = sclk_i;
      if (cs_n_i) begin
        m_active = 0; m_strobe = 0; m_done = 0; m_sdo = 0; m_oe = 0; m_cnt = 0;
      end else begin
        if (m_done) begin m_sdo = 0; m_oe = 0; end
        m_done = 0;
        if (m_active) begin
          if (ev) begin
            m_strobe = rise;
            m_cnt++;
            if (rise || m_ddr) begin
              m_sdo = 0; m_oe = 0;
              for (int l = 0; l < m_nl; l++) begin
                m_sdo[l] = mq.pop_front();
                m_oe[l] = 1;
              end
            end
            if (m_cnt == m_total) begin m_active = 0; m_done = 1; end
          end
        end else if (start_i && (proto_i == 3'b010 || proto_i == 3'b011) && width_i != 2'b11) begin
          m_ddr = proto_i[0]; m_ext = src_ext_i; m_nl = 1 << width_i;
          m_total = (m_ddr ? 16 : 32) / m_nl;
          mq.delete();
          for (int b = 15; b >= 0; b--) mq.push_back(word_i[b]);
          m_active = 1; m_cnt = 0;
        end
      end
    end
  end

  // ---------------- per-cycle compare and host capture ----------------
  bit cur_ddr, prev_s;
  int cur_nl, rises, busy_cyc;
  bit [15:0] cap;

  always @(negedge clk) begin
    if (!rst && cmp_en) begin
      chk(strobe_o === m_strobe, m_ext ? "R8 strobe" : "R3 strobe", strobe_o, m_strobe);
      chk(sdo_o === m_sdo, "R4 lane data", sdo_o, m_sdo);
      chk(sdo_oe_o === m_oe, "R7 lane enables", sdo_oe_o, m_oe);
      chk(busy_o === m_active, "R2 busy", busy_o, m_active);
      chk(done_o === m_done, "R11 done", done_o, m_done);
      if ((busy_o || done_o) && strobe_o != prev_s && (strobe_o || cur_ddr))
        for (int l = 0; l < cur_nl; l++) cap = {cap[14:0], sdo_o[l]};
      if (strobe_o && !prev_s) rises++;
      if (busy_o) busy_cyc++;
    end
    prev_s = strobe_o;
  end

  task automatic xfer(input bit [15:0] w, input bit [2:0] pr, input bit [1:0] wd,
                      input bit ext, input bit perturb);
    int e;
    bit seen;
    cur_ddr = pr[0]; cur_nl = 1 << wd; cap = 0; rises = 0; busy_cyc = 0; seen = 0;
    e = (cur_ddr ? 16 : 32) / cur_nl;
    @(negedge clk);
    word_i = w; proto_i = pr; width_i = wd; src_ext_i = ext; start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (perturb) begin
      repeat (3) @(negedge clk);
      proto_i = 3'b011; width_i = 2'b10; src_ext_i = ~ext; word_i = ~w; start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (done_o) seen = 1;
    end
    @(negedge clk);
    chk(seen, "R11 done seen", seen, 1);
    chk(cap == w, perturb ? "R10 word after mid-transfer change" : "R4 captured word", cap, w);
    chk(rises == e / 2, cur_ddr ? "R6 rising edge count" : "R5 rising edge count", rises, e / 2);
    if (!ext) chk(busy_cyc == e, cur_ddr ? "R6 length" : "R5 length", busy_cyc, e);
    if (perturb) chk(busy_cyc == e, "R10 length unchanged", busy_cyc, e);
    proto_i = 3'b010; width_i = 2'b00; src_ext_i = 0;
  endtask

  task automatic bad_start(input bit [2:0] pr, input bit [1:0] wd, input bit csn);
    @(negedge clk);
    proto_i = pr; width_i = wd; cs_n_i = csn; start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (2) @(negedge clk);
    chk(!busy_o && !strobe_o && sdo_oe_o == 0, "R2 start ignored", {busy_o, strobe_o, sdo_oe_o}, 0);
    cs_n_i = 0; proto_i = 3'b010; width_i = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(strobe_o == 0, "R1 strobe after reset", strobe_o, 0);
    chk(sdo_oe_o == 0 && sdo_o == 0, "R1 lanes after reset", {sdo_oe_o, sdo_o}, 0);
    chk(busy_o == 0 && done_o == 0, "R1 flags after reset", {busy_o, done_o}, 0);
    cmp_en = 1;

    xfer(16'hA5C3, 3'b010, 2'b00, 0, 0);
    xfer(16'h1234, 3'b010, 2'b01, 0, 0);
    xfer(16'hF00F, 3'b010, 2'b10, 0, 0);
    xfer(16'h8001, 3'b011, 2'b00, 0, 0);
    xfer(16'h6DB6, 3'b011, 2'b01, 0, 0);
    xfer(16'h3C5A, 3'b011, 2'b10, 0, 0);
    xfer(16'hBEEF, 3'b010, 2'b01, 1, 0);
    xfer(16'h7E81, 3'b011, 2'b00, 1, 0);
    xfer(16'hC0DE, 3'b011, 2'b10, 1, 0);
    xfer(16'h9669, 3'b010, 2'b00, 0, 1);

    bad_start(3'b001, 2'b00, 0);
    bad_start(3'b010, 2'b11, 0);
    bad_start(3'b011, 2'b01, 1);

    // cancel mid-transfer
    @(negedge clk);
    word_i = 16'h5AA5; proto_i = 3'b010; width_i = 2'b00; src_ext_i = 0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (6) @(negedge clk);
    cs_n_i = 1;
    @(negedge clk);
    chk(!strobe_o && sdo_oe_o == 0 && !busy_o && !done_o, "R9 cancel clears",
        {strobe_o, sdo_oe_o, busy_o, done_o}, 0);
    cs_n_i = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!done_o && !busy_o, "R9 no done after cancel", {done_o, busy_o}, 0);
    end

    xfer(16'h0F1E, 3'b011, 2'b01, 1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule